// File: doc/BRIEF.md
# Conversion Queue Scan Sequencer

This block steps through a short list of conversion commands for an analog-to-digital converter. Each command names an input channel and may carry a pause bit. A scan begins when the trigger source picked by the scan mode fires. The source is a software start, an external trigger pulse, an interval-timer tick, or the opening of an external gate. For each command the block sends a start strobe with the channel number. It then waits for the converter's done pulse before it moves to the next command.

What a pause bit does depends on the trigger source. In externally triggered and timer modes the scan halts after the paused conversion, and the next trigger resumes it. Software-started scans only record the pause and keep going. Gated scans ignore pause bits. In gated modes the status flag instead reports a scan that the gate cut short. The flag stays set until software reads it as 1 and then writes 0. The interrupt line follows the flag when the interrupt is enabled.

Top module: `qscan_seq`

## Requirements
- R1: `scan_mode[1:0]` picks the trigger: 0 means a `sw_start` pulse, 1 means an `ext_trig` pulse, 2 means a `timer_tick` pulse, and 3 means a rising edge of `gate`. `scan_mode[2]`=1 selects continuous scanning and 0 selects single scanning. When the queue is enabled and the chosen trigger fires while the block is idle, a scan starts at entry 0.
- R2: Entry i occupies `cmd_table[7*i +: 7]`. Bit 6 is the pause bit and bits 5:0 are the channel. The queue ends at channel code 63, or after entry 15 when no code 63 appears. Every other entry is issued in index order as a one-cycle `conv_start` with its channel on `conv_chan`.
- R3: At most one conversion is outstanding. The next `conv_start` comes only after the `conv_done` for the current one.
- R4: In trigger modes 1 and 2, a paused entry sets the flag and stops the scan once its conversion is done. The next trigger pulse resumes the scan at the following entry.
- R5: In mode 0, a paused entry sets the flag and the scan continues without any new trigger.
- R6: In mode 3, pause bits neither stop the scan nor set the flag.
- R7: In mode 3, if `gate` is low when the next entry is due and the end of the queue has not been reached, the flag is set and the scan is abandoned. In continuous form, the next gate rising edge restarts the scan at entry 0.
- R8: At the end of the queue, a continuous scan waits for the next trigger and restarts at entry 0. A single scan disables the queue, so triggers are ignored until an `arm` pulse.
- R9: The flag is set and held whatever the value of `irq_en`. `irq` is high exactly when the flag is 1 and `irq_en` is 1.
- R10: A `flag_wr` with `flag_wdata`=0 clears the flag only if a `flag_rd` earlier found the flag at 1. Otherwise the flag is unchanged. Writing 1 has no effect.
- R11: When a set event and a valid clear fall in the same cycle, the flag stays 1.
- R12: After reset the flag, `irq` and `conv_start` are 0 and the queue is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_mode | input | 3 | Trigger source (bits 1:0) and continuous select (bit 2) |
| arm | input | 1 | Pulse that enables the queue |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger pulse |
| timer_tick | input | 1 | Interval timer pulse |
| gate | input | 1 | External gate level |
| cmd_table | input | 112 | Sixteen 7-bit command entries |
| conv_done | input | 1 | Converter finished the current conversion |
| flag_rd | input | 1 | Read strobe for the status flag |
| flag_wr | input | 1 | Write strobe for the status flag |
| flag_wdata | input | 1 | Write data for the status flag |
| irq_en | input | 1 | Interrupt enable |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 6 | Channel of the conversion being started |
| pause_flag | output | 1 | Pause / incomplete-scan flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a set event and a valid clear in the same clock edge. To set it up, the bench parks an externally triggered scan on a pause and reads the flag. It then resumes with automatic completion turned off. Finally it drives the converter's done pulse for a second paused entry in the same cycle as the write of 0. A gate that closes part-way through a scan is the other awkward case. The bench drops `gate` just after the second start strobe appears, so the closure is seen exactly when the third command falls due.

// File: rtl/qscan_pkg.sv
package qscan_pkg;
    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TMR  = 2'd2,
        SRC_GATE = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_HOLD
    } seq_st_e;
endpackage

// File: rtl/qscan_trig_sel.sv
module qscan_trig_sel
    import qscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e src,
    input  logic      sw_start,
    input  logic      ext_trig,
    input  logic      timer_tick,
    input  logic      gate,
    output logic      fire
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d = gate;
        unique case (src)
            SRC_SW:   fire = sw_start;
            SRC_EXT:  fire = ext_trig;
            SRC_TMR:  fire = timer_tick;
            default:  fire = gate & ~gate_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/qscan_cmd_pick.sv
module qscan_cmd_pick #(
    parameter int ENTRIES = 16,
    parameter int CHAN_W  = 6,
    localparam int CMD_W  = CHAN_W + 1,
    localparam int IDX_W  = $clog2(ENTRIES + 1),
    localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES*CMD_W-1:0] table_in,
    input  logic [IDX_W-1:0]         idx,
    output logic [CHAN_W-1:0]        chan,
    output logic                     pause,
    output logic                     eoq
);
    logic [CMD_W-1:0] words [ENTRIES];
    logic [CMD_W-1:0] cur;
    logic             in_range;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
        assign words[g] = table_in[g*CMD_W +: CMD_W];
    end

    always_comb begin
        in_range = (idx < IDX_W'(ENTRIES));
        cur      = words[idx[SEL_W-1:0]];
        chan     = cur[CHAN_W-1:0];
        pause    = cur[CHAN_W];
        eoq      = !in_range || (cur[CHAN_W-1:0] == {CHAN_W{1'b1}});
    end
endmodule

// File: rtl/qscan_flag.sv
module qscan_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd,
    input  logic wr,
    input  logic wdata,
    output logic flag
);
    typedef struct packed {
        logic flag;
        logic seen_one;
    } flag_t;

    flag_t d, q;

    always_comb begin
        d = q;
        if (rd && q.flag) d.seen_one = 1'b1;
        if (wr && !wdata && q.seen_one) begin
            d.flag     = 1'b0;
            d.seen_one = 1'b0;
        end
        if (set_ev) d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;
endmodule

// File: rtl/qscan_seq.sv
module qscan_seq
    import qscan_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CHAN_W  = 6,
    localparam int CMD_W  = CHAN_W + 1,
    localparam int IDX_W  = $clog2(ENTRIES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               scan_mode,
    input  logic                     arm,
    input  logic                     sw_start,
    input  logic                     ext_trig,
    input  logic                     timer_tick,
    input  logic                     gate,
    input  logic [ENTRIES*CMD_W-1:0] cmd_table,
    input  logic                     conv_done,
    input  logic                     flag_rd,
    input  logic                     flag_wr,
    input  logic                     flag_wdata,
    input  logic                     irq_en,
    output logic                     conv_start,
    output logic [CHAN_W-1:0]        conv_chan,
    output logic                     pause_flag,
    output logic                     irq
);
    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic              en;
        logic              start;
        logic [CHAN_W-1:0] chan;
        logic              pause;
    } seq_t;

    seq_t d, q;

    trig_src_e         src;
    logic              cont, gated, halting, fire;
    logic [CHAN_W-1:0] cmd_chan;
    logic              cmd_pause, cmd_eoq, flag_set;

    assign src     = trig_src_e'(scan_mode[1:0]);
    assign cont    = scan_mode[2];
    assign gated   = (src == SRC_GATE);
    assign halting = (src == SRC_EXT) || (src == SRC_TMR);

    qscan_trig_sel u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (src),
        .sw_start   (sw_start),
        .ext_trig   (ext_trig),
        .timer_tick (timer_tick),
        .gate       (gate),
        .fire       (fire)
    );

    qscan_cmd_pick #(.ENTRIES(ENTRIES), .CHAN_W(CHAN_W)) u_pick (
        .table_in (cmd_table),
        .idx      (q.idx),
        .chan     (cmd_chan),
        .pause    (cmd_pause),
        .eoq      (cmd_eoq)
    );

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        flag_set = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.en && fire) begin
                    d.idx = '0;
                    d.st  = ST_ISSUE;
                end
            end
            ST_HOLD: begin
                if (fire) d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (cmd_eoq) begin
                    d.st = ST_IDLE;
                    if (!cont) d.en = 1'b0;
                end else if (gated && !gate) begin
                    flag_set = 1'b1;
                    d.st     = ST_IDLE;
                    if (!cont) d.en = 1'b0;
                end else begin
                    d.start = 1'b1;
                    d.chan  = cmd_chan;
                    d.pause = cmd_pause;
                    d.st    = ST_WAIT;
                end
            end
            default: begin
                if (conv_done) begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_ISSUE;
                    if (q.pause && !gated) begin
                        flag_set = 1'b1;
                        if (halting) d.st = ST_HOLD;
                    end
                end
            end
        endcase
        if (arm) d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    qscan_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (flag_set),
        .rd     (flag_rd),
        .wr     (flag_wr),
        .wdata  (flag_wdata),
        .flag   (pause_flag)
    );

    assign conv_start = q.start;
    assign conv_chan  = q.chan;
    assign irq        = pause_flag & irq_en;
endmodule

// File: rtl/qscan_chk.sv
module qscan_chk #(
    parameter int CHAN_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic [CHAN_W-1:0] conv_chan,
    input logic              conv_done,
    input logic              pause_flag,
    input logic              flag_wr,
    input logic              flag_wdata,
    input logic              irq_en,
    input logic              irq
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_q <= 1'b0;
        else if (conv_start) busy_q <= 1'b1;
        else if (conv_done)  busy_q <= 1'b0;
    end

    a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !busy_q);

    a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r2_end_code_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan != {CHAN_W{1'b1}}));

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_flag && !(flag_wr && !flag_wdata)) |=> pause_flag);

    a_r10_fall_needs_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pause_flag) |-> $past(flag_wr && !flag_wdata));

    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pause_flag && irq_en));
endmodule

bind qscan_seq qscan_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .pause_flag (pause_flag),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .irq_en     (irq_en),
    .irq        (irq)
);

// File: tb/sim_qscan_seq.sv
module sim_qscan_seq;
    localparam int ENTRIES = 16;
    localparam int CHAN_W  = 6;
    localparam int CMD_W   = CHAN_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] scan_mode = '0;
    logic arm = 0, sw_start = 0, ext_trig = 0, timer_tick = 0, gate = 0;
    logic [ENTRIES*CMD_W-1:0] cmd_table = '0;
    logic conv_done;
    logic done_auto = 0, done_man = 0;
    logic flag_rd = 0, flag_wr = 0, flag_wdata = 0, irq_en = 0;
    logic conv_start;
    logic [CHAN_W-1:0] conv_chan;
    logic pause_flag, irq;

    int checks = 0;
    int errors = 0;
    logic [5:0] seen [64];
    int nseen = 0;
    int overlap = 0;
    bit auto_done = 1;

    always #10 clk = ~clk;
    assign conv_done = done_auto | done_man;

    qscan_seq u0 (
        .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .arm(arm),
        .sw_start(sw_start), .ext_trig(ext_trig), .timer_tick(timer_tick),
        .gate(gate), .cmd_table(cmd_table), .conv_done(conv_done),
        .flag_rd(flag_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .irq_en(irq_en), .conv_start(conv_start), .conv_chan(conv_chan),
        .pause_flag(pause_flag), .irq(irq)
    );

    // converter stand-in: logs each start, answers two cycles later
    initial begin
        bit outs = 0;
        int dly = 0;
        forever begin
            @(negedge clk);
            if (conv_done) outs = 0;
            done_auto = 0;
            if (dly > 0) begin
                dly--;
                if (dly == 0) done_auto = 1;
            end
            if (conv_start) begin
                if (outs) overlap++;
                outs = 1;
                if (nseen < 64) seen[nseen] = conv_chan;
                nseen++;
                if (auto_done) dly = 2;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(int i, bit p, logic [5:0] ch);
        cmd_table[i*CMD_W +: CMD_W] = {p, ch};
    endtask

    task automatic pulse_arm;
        @(negedge clk) arm = 1; @(negedge clk) arm = 0;
    endtask
    task automatic pulse_sw;
        @(negedge clk) sw_start = 1; @(negedge clk) sw_start = 0;
    endtask
    task automatic pulse_ext;
        @(negedge clk) ext_trig = 1; @(negedge clk) ext_trig = 0;
    endtask
    task automatic pulse_tmr;
        @(negedge clk) timer_tick = 1; @(negedge clk) timer_tick = 0;
    endtask
    task automatic read_flag;
        @(negedge clk) flag_rd = 1; @(negedge clk) flag_rd = 0;
    endtask
    task automatic write_flag(bit v);
        @(negedge clk) begin flag_wr = 1; flag_wdata = v; end
        @(negedge clk) flag_wr = 0;
    endtask
    task automatic clear_flag;
        read_flag();
        write_flag(0);
    endtask

    task automatic t_reset;
        wait_cyc(1);
        chk(pause_flag == 0, "R12 flag", int'(pause_flag), 0);
        chk(irq == 0, "R12 irq", int'(irq), 0);
        chk(conv_start == 0, "R12 start", int'(conv_start), 0);
        scan_mode = 3'd0;
        put(0, 0, 6'd1); put(1, 0, 6'd63);
        pulse_sw();
        wait_cyc(20);
        chk(nseen == 0, "R12 queue disabled", nseen, 0);
    endtask

    task automatic t_sw_single;
        nseen = 0;
        scan_mode = 3'd0;
        put(0, 0, 6'd5); put(1, 0, 6'd9); put(2, 0, 6'd12); put(3, 0, 6'd63);
        pulse_arm();
        pulse_sw();
        wait_cyc(40);
        chk(nseen == 3, "R1 R2 count", nseen, 3);
        chk(seen[0] == 5 && seen[1] == 9 && seen[2] == 12, "R2 order",
            int'(seen[2]), 12);
        chk(pause_flag == 0, "R2 no flag", int'(pause_flag), 0);
        pulse_sw();
        wait_cyc(30);
        chk(nseen == 3, "R8 single disables", nseen, 3);
    endtask

    task automatic t_full_table;
        nseen = 0;
        scan_mode = 3'd0;
        for (int i = 0; i < ENTRIES; i++) put(i, 0, 6'(i + 40));
        pulse_arm();
        pulse_sw();
        wait_cyc(140);
        chk(nseen == ENTRIES, "R2 sixteen entry limit", nseen, ENTRIES);
        chk(seen[15] == 55, "R2 last entry", int'(seen[15]), 55);
    endtask

    task automatic t_ext_pause;
        nseen = 0;
        irq_en = 0;
        scan_mode = 3'd1;
        put(0, 0, 6'd1); put(1, 1, 6'd2); put(2, 0, 6'd3); put(3, 0, 6'd63);
        pulse_arm();
        pulse_ext();
        wait_cyc(40);
        chk(nseen == 2, "R4 halts at pause", nseen, 2);
        chk(pause_flag == 1, "R4 flag set", int'(pause_flag), 1);
        chk(irq == 0, "R9 irq masked", int'(irq), 0);
        irq_en = 1;
        wait_cyc(1);
        chk(irq == 1, "R9 irq enabled", int'(irq), 1);
        pulse_ext();
        wait_cyc(30);
        chk(nseen == 3 && seen[2] == 3, "R4 resumes next entry", nseen, 3);
        write_flag(0);
        wait_cyc(1);
        chk(pause_flag == 1, "R10 clear without read", int'(pause_flag), 1);
        read_flag();
        write_flag(1);
        wait_cyc(1);
        chk(pause_flag == 1, "R10 write one", int'(pause_flag), 1);
        write_flag(0);
        wait_cyc(1);
        chk(pause_flag == 0, "R10 read then clear", int'(pause_flag), 0);
        irq_en = 0;
    endtask

    task automatic t_sw_pause;
        nseen = 0;
        scan_mode = 3'd0;
        put(0, 0, 6'd1); put(1, 1, 6'd2); put(2, 0, 6'd3); put(3, 0, 6'd63);
        pulse_arm();
        pulse_sw();
        wait_cyc(40);
        chk(nseen == 3, "R5 continues past pause", nseen, 3);
        chk(pause_flag == 1, "R5 flag set", int'(pause_flag), 1);
        clear_flag();
    endtask

    task automatic t_timer_cont;
        nseen = 0;
        scan_mode = 3'd6;
        put(0, 0, 6'd4); put(1, 0, 6'd7); put(2, 0, 6'd63);
        pulse_arm();
        pulse_tmr();
        wait_cyc(30);
        chk(nseen == 2, "R1 timer scan", nseen, 2);
        pulse_tmr();
        wait_cyc(30);
        chk(nseen == 4 && seen[2] == 4, "R8 continuous restart", int'(seen[2]), 4);
    endtask

    task automatic t_gate_full;
        nseen = 0;
        scan_mode = 3'd3;
        put(0, 0, 6'd10); put(1, 1, 6'd11); put(2, 0, 6'd12); put(3, 0, 6'd63);
        pulse_arm();
        @(negedge clk) gate = 1;
        wait_cyc(50);
        chk(nseen == 3, "R6 pause ignored", nseen, 3);
        chk(pause_flag == 0, "R6 no flag", int'(pause_flag), 0);
        @(negedge clk) gate = 0;
    endtask

    task automatic t_gate_drop;
        nseen = 0;
        scan_mode = 3'd7;
        put(0, 0, 6'd20); put(1, 0, 6'd21); put(2, 0, 6'd22); put(3, 0, 6'd23);
        put(4, 0, 6'd63);
        pulse_arm();
        @(negedge clk) gate = 1;
        for (int k = 0; k < 100 && nseen < 2; k++) @(negedge clk);
        gate = 0;
        wait_cyc(30);
        chk(nseen == 2, "R7 scan abandoned", nseen, 2);
        chk(pause_flag == 1, "R7 incomplete flag", int'(pause_flag), 1);
        clear_flag();
        @(negedge clk) gate = 1;
        wait_cyc(60);
        chk(nseen == 6 && seen[2] == 20, "R7 restart at entry 0", int'(seen[2]), 20);
        chk(pause_flag == 0, "R7 complete scan no flag", int'(pause_flag), 0);
        @(negedge clk) gate = 0;
    endtask

    task automatic t_set_wins;
        nseen = 0;
        scan_mode = 3'd1;
        put(0, 1, 6'd30); put(1, 1, 6'd31); put(2, 0, 6'd63);
        pulse_arm();
        pulse_ext();
        wait_cyc(30);
        chk(pause_flag == 1, "R4 first pause", int'(pause_flag), 1);
        read_flag();
        auto_done = 0;
        pulse_ext();
        wait_cyc(6);
        chk(nseen == 2, "R3 waits for done", nseen, 2);
        @(negedge clk) begin done_man = 1; flag_wr = 1; flag_wdata = 0; end
        @(negedge clk) begin done_man = 0; flag_wr = 0; end
        wait_cyc(1);
        chk(pause_flag == 1, "R11 set wins", int'(pause_flag), 1);
        auto_done = 1;
        clear_flag();
        wait_cyc(1);
        chk(pause_flag == 0, "R10 clear after set wins", int'(pause_flag), 0);
        pulse_ext();
        wait_cyc(10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_sw_single();
        t_full_table();
        t_ext_pause();
        t_sw_pause();
        t_timer_cont();
        t_gate_full();
        t_gate_drop();
        t_set_wins();
        chk(overlap == 0, "R3 no overlap", overlap, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule